// File: doc/BRIEF.md
# Bit-Oriented Frame Receiver

This block takes a bit-synchronous serial line, one bit per clock where `bit_en` is high, and recovers the frames on it. It stays silent until it sees an opening flag (`01111110`). Inside a frame it removes the zeros the sender stuffed after runs of five ones. It groups the remaining bits into characters, least significant bit first. Each frame is checked with a 16-bit CRC preset to all ones. The receiver reports every flag on `sync_pulse`, and it reports the start and the end of an abort sequence. At each closing flag it gives a one-cycle end-of-frame strobe with a CRC error flag.

The first character of a frame is always an 8-bit address byte. When address search is on, a frame whose address is neither `cfg_station` nor the broadcast value 0xFF is dropped entirely: it produces no characters and no end-of-frame. The characters after the address use a programmable length of 1 to 8 bits. A received bit cannot be classed as data until the next seven bits show that it is not part of a flag. For this reason, each character appears seven accepted line bits after its last bit arrived.

Stream rules: the serial input is a qualified stream without a ready, because a line cannot be stalled. A bit is taken on every clock with `bit_en` high. The character output also has no ready. The consumer must take each `char_valid` strobe in the cycle it appears, and at most one strobe can occur for each accepted bit. The configuration inputs must be held stable while a frame is in progress.

Top module: `hdlc_rx_frame`

## Requirements
- R1: A flag is a 0, then six ones, then a 0 on accepted bits. `sync_pulse` is high for exactly the one cycle after the clock edge that takes the final 0 of each flag, whether a frame is open or not.
- R2: A 0 that follows exactly five consecutive accepted ones is deleted. It is not counted toward any character and does not enter the CRC.
- R3: Data bits are packed least significant bit first, and `char_valid` pulses for one cycle when a character completes. The first character after a flag is 8 bits wide and is marked by `char_first`. Later characters are `cfg_char_bits` wide, where code 0 means 8. Each is right-aligned in `char_data` with the unused upper bits at zero.
- R4: The CRC starts at 0xFFFF at each flag and runs over all non-stuffed bits between flags, least significant bit first, with polynomial x^16+x^12+x^5+1. At the end of the frame, `eof_crc_err` is 0 exactly when the remainder equals 0xF0B8.
- R5: `eof_valid` pulses together with the `sync_pulse` of a closing flag, but only when the frame accepted at least one data bit and was neither dropped nor aborted. A flag that directly follows a flag produces no end-of-frame. One flag can close one frame and open the next.
- R6: When `cfg_addr_en` is 1, a frame whose 8-bit address is neither `cfg_station` nor 0xFF produces no characters and no end-of-frame until the next flag. When `cfg_addr_en` is 0, every frame is delivered.
- R7: A seventh consecutive one pulses `abort_start`. Any open frame is dropped without an end-of-frame, and nothing more is delivered until a new flag arrives.
- R8: The first 0 after seven or more consecutive ones pulses `abort_end`.
- R9: Clocks with `bit_en` low change nothing. Every output strobe appears only in the cycle after a clock with `bit_en` high, and at most one of `sync_pulse`, `char_valid`, `abort_start` and `abort_end` is high in any cycle.
- R10: After reset all strobes are low and the receiver is hunting, so no character is delivered before the first flag.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| bit_en | input | 1 | Qualifies `rx_bit` on this clock |
| rx_bit | input | 1 | Serial line bit |
| cfg_char_bits | input | 3 | Character length after the address, 0 means 8 |
| cfg_addr_en | input | 1 | Enables address search |
| cfg_station | input | 8 | Station address to accept |
| sync_pulse | output | 1 | Flag recognised |
| char_valid | output | 1 | Character strobe |
| char_data | output | 8 | Received character, right-aligned |
| char_first | output | 1 | Character is the address byte |
| eof_valid | output | 1 | End-of-frame strobe |
| eof_crc_err | output | 1 | CRC remainder wrong; valid with `eof_valid` |
| abort_start | output | 1 | Abort sequence began |
| abort_end | output | 1 | Abort sequence ended |

## Verification
A model in the bench predicts every output for every accepted bit, and this prediction is compared on each clock. The frames sent include bytes 0xFF and 0x7E, so that zero deletion is tested against flag recognition. A flipped FCS bit separates a good CRC remainder from a bad one. Two frames share a flag, and a run of bare flags tells a closing flag from an idle one. A 5-bit character length combined with gaps in `bit_en` exercises packing and gating. The addresses sent are the station address, the broadcast value and a foreign address, which shows that filtering looks at the first byte only. An abort placed in the middle of a frame shows that the frame is dropped, that both abort edges are reported, and that reception recovers on the next frame.

// File: rtl/hdlc_rx_pkg.sv
package hdlc_rx_pkg;
  typedef enum logic [2:0] {
    BK_IDLE,   // further one inside an abort run
    BK_DATA,   // candidate data bit
    BK_STUFF,  // inserted zero, dropped
    BK_FLAG,   // final zero of a flag
    BK_ABORT,  // seventh consecutive one
    BK_ABEND   // first zero after an abort run
  } bit_kind_e;
endpackage

// File: rtl/hdlc_rx_line.sv
module hdlc_rx_line
  import hdlc_rx_pkg::*;
#(
  parameter int STUFF_RUN = 5
) (
  input  logic      clk,
  input  logic      rst_n,
  input  logic      bit_en,
  input  logic      rx_bit,
  output bit_kind_e kind
);
  localparam int FLAG_RUN  = STUFF_RUN + 1;
  localparam int ABORT_RUN = STUFF_RUN + 2;
  localparam int RUN_W     = $clog2(ABORT_RUN + 1);

  logic [RUN_W-1:0] run_q;

  always_comb begin
    if (rx_bit) begin
      if (run_q == RUN_W'(FLAG_RUN))       kind = BK_ABORT;
      else if (run_q == RUN_W'(ABORT_RUN)) kind = BK_IDLE;
      else                                 kind = BK_DATA;
    end else begin
      if (run_q == RUN_W'(STUFF_RUN))      kind = BK_STUFF;
      else if (run_q == RUN_W'(FLAG_RUN))  kind = BK_FLAG;
      else if (run_q == RUN_W'(ABORT_RUN)) kind = BK_ABEND;
      else                                 kind = BK_DATA;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      run_q <= '0;
    end else if (bit_en) begin
      if (!rx_bit)                              run_q <= '0;
      else if (run_q != RUN_W'(ABORT_RUN))      run_q <= run_q + RUN_W'(1);
    end
  end
endmodule

// File: rtl/hdlc_rx_delay.sv
module hdlc_rx_delay #(
  parameter int DEPTH = 7
) (
  input  logic clk,
  input  logic rst_n,
  input  logic clear,
  input  logic push,
  input  logic din,
  output logic rel_valid,
  output logic rel_bit
);
  localparam int FILL_W = $clog2(DEPTH + 1);

  logic [DEPTH-1:0]  sr_q;
  logic [FILL_W-1:0] fill_q;
  logic              full;

  assign full      = (fill_q == FILL_W'(DEPTH));
  assign rel_valid = push && full;
  assign rel_bit   = sr_q[DEPTH-1];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sr_q   <= '0;
      fill_q <= '0;
    end else if (clear) begin
      fill_q <= '0;
    end else if (push) begin
      sr_q <= {sr_q[DEPTH-2:0], din};
      if (!full) fill_q <= fill_q + FILL_W'(1);
    end
  end
endmodule

// File: rtl/hdlc_rx_crc.sv
module hdlc_rx_crc #(
  parameter int              CRC_W = 16,
  parameter logic [CRC_W-1:0] POLY = 16'h8408,
  parameter logic [CRC_W-1:0] INIT = 16'hFFFF
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             init,
  input  logic             upd,
  input  logic             din,
  output logic [CRC_W-1:0] crc
);
  logic [CRC_W-1:0] nxt;

  always_comb begin
    nxt = crc >> 1;
    if (crc[0] ^ din) nxt = nxt ^ POLY;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)    crc <= INIT;
    else if (init) crc <= INIT;
    else if (upd)  crc <= nxt;
  end
endmodule

// File: rtl/hdlc_rx_frame.sv
module hdlc_rx_frame
  import hdlc_rx_pkg::*;
#(
  parameter int          CHAR_MAX   = 8,
  parameter int          STUFF_RUN  = 5,
  parameter logic [7:0]  BCAST_ADDR = 8'hFF,
  parameter logic [15:0] CRC_GOOD   = 16'hF0B8
) (
  input  logic                        clk,
  input  logic                        rst_n,
  input  logic                        bit_en,
  input  logic                        rx_bit,
  input  logic [$clog2(CHAR_MAX)-1:0] cfg_char_bits,
  input  logic                        cfg_addr_en,
  input  logic [CHAR_MAX-1:0]         cfg_station,
  output logic                        sync_pulse,
  output logic                        char_valid,
  output logic [CHAR_MAX-1:0]         char_data,
  output logic                        char_first,
  output logic                        eof_valid,
  output logic                        eof_crc_err,
  output logic                        abort_start,
  output logic                        abort_end
);
  localparam int CNT_W = $clog2(CHAR_MAX + 1);
  localparam int HOLD  = STUFF_RUN + 2;

  bit_kind_e            kind;
  logic                 rel_valid, rel_bit;
  logic [15:0]          crc;
  logic                 active_q, reject_q, got_q, first_q;
  logic [CNT_W-1:0]     cnt_q, cnt_nx, target, shamt;
  logic [CHAR_MAX-1:0]  sr_q, shifted, char_out;
  logic                 addr_ok, is_flag, push;

  assign is_flag = bit_en && (kind == BK_FLAG);
  assign push    = bit_en && (kind == BK_DATA) && active_q;

  hdlc_rx_line #(.STUFF_RUN(STUFF_RUN)) u_line (
    .clk(clk), .rst_n(rst_n), .bit_en(bit_en), .rx_bit(rx_bit), .kind(kind)
  );

  hdlc_rx_delay #(.DEPTH(HOLD)) u_delay (
    .clk(clk), .rst_n(rst_n), .clear(is_flag), .push(push), .din(rx_bit),
    .rel_valid(rel_valid), .rel_bit(rel_bit)
  );

  hdlc_rx_crc #(.CRC_W(16), .POLY(16'h8408), .INIT(16'hFFFF)) u_crc (
    .clk(clk), .rst_n(rst_n), .init(is_flag), .upd(rel_valid), .din(rel_bit),
    .crc(crc)
  );

  always_comb begin
    if (first_q || cfg_char_bits == '0) target = CNT_W'(CHAR_MAX);
    else                                target = CNT_W'(cfg_char_bits);
    shamt    = CNT_W'(CHAR_MAX) - target;
    cnt_nx   = cnt_q + CNT_W'(1);
    shifted  = {rel_bit, sr_q[CHAR_MAX-1:1]};
    char_out = shifted >> shamt;
    addr_ok  = !first_q || !cfg_addr_en ||
               (shifted == cfg_station) || (shifted == BCAST_ADDR);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sync_pulse  <= 1'b0;
      char_valid  <= 1'b0;
      char_data   <= '0;
      char_first  <= 1'b0;
      eof_valid   <= 1'b0;
      eof_crc_err <= 1'b0;
      abort_start <= 1'b0;
      abort_end   <= 1'b0;
      active_q    <= 1'b0;
      reject_q    <= 1'b0;
      got_q       <= 1'b0;
      first_q     <= 1'b1;
      cnt_q       <= '0;
      sr_q        <= '0;
    end else begin
      sync_pulse  <= 1'b0;
      char_valid  <= 1'b0;
      eof_valid   <= 1'b0;
      abort_start <= 1'b0;
      abort_end   <= 1'b0;
      if (bit_en) begin
        unique case (kind)
          BK_FLAG: begin
            sync_pulse <= 1'b1;
            if (active_q && !reject_q && got_q) begin
              eof_valid   <= 1'b1;
              eof_crc_err <= (crc != CRC_GOOD);
            end
            active_q <= 1'b1;
            reject_q <= 1'b0;
            got_q    <= 1'b0;
            first_q  <= 1'b1;
            cnt_q    <= '0;
          end
          BK_ABORT: begin
            abort_start <= 1'b1;
            active_q    <= 1'b0;
          end
          BK_ABEND: abort_end <= 1'b1;
          default: ;
        endcase
        if (rel_valid) begin
          got_q <= 1'b1;
          if (!reject_q) begin
            sr_q <= shifted;
            if (cnt_nx == target) begin
              cnt_q   <= '0;
              first_q <= 1'b0;
              if (addr_ok) begin
                char_valid <= 1'b1;
                char_data  <= char_out;
                char_first <= first_q;
              end else begin
                reject_q <= 1'b1;
              end
            end else begin
              cnt_q <= cnt_nx;
            end
          end
        end
      end
    end
  end
endmodule

// File: rtl/hdlc_rx_frame_chk.sv
module hdlc_rx_frame_chk #(
  parameter int         CHAR_MAX   = 8,
  parameter logic [7:0] BCAST_ADDR = 8'hFF
) (
  input logic                        clk,
  input logic                        rst_n,
  input logic                        bit_en,
  input logic [$clog2(CHAR_MAX)-1:0] cfg_char_bits,
  input logic                        cfg_addr_en,
  input logic [CHAR_MAX-1:0]         cfg_station,
  input logic                        sync_pulse,
  input logic                        char_valid,
  input logic [CHAR_MAX-1:0]         char_data,
  input logic                        char_first,
  input logic                        eof_valid,
  input logic                        abort_start,
  input logic                        abort_end
);
  logic ab_q, open_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ab_q   <= 1'b0;
      open_q <= 1'b0;
    end else begin
      if (abort_start)    ab_q <= 1'b1;
      else if (abort_end) ab_q <= 1'b0;
      if (sync_pulse)       open_q <= 1'b1;
      else if (abort_start) open_q <= 1'b0;
    end
  end

  AST_EVENT_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({sync_pulse, char_valid, abort_start, abort_end})); // R9

  AST_STROBE_NEEDS_BIT: assert property (@(posedge clk) disable iff (!rst_n)
    (sync_pulse || char_valid || abort_start || abort_end) |-> $past(bit_en)); // R9

  AST_EOF_ON_FLAG: assert property (@(posedge clk) disable iff (!rst_n)
    eof_valid |-> sync_pulse); // R5

  AST_ABEND_AFTER_START: assert property (@(posedge clk) disable iff (!rst_n)
    abort_end |-> ab_q); // R8

  AST_CHAR_NEEDS_FLAG: assert property (@(posedge clk) disable iff (!rst_n)
    char_valid |-> open_q); // R10

  AST_ADDR_PASS: assert property (@(posedge clk) disable iff (!rst_n)
    (char_valid && char_first && cfg_addr_en) |->
      (char_data == cfg_station || char_data == BCAST_ADDR)); // R6

  AST_CHAR_FIT: assert property (@(posedge clk) disable iff (!rst_n)
    (char_valid && !char_first && cfg_char_bits != '0) |->
      ((char_data >> cfg_char_bits) == '0)); // R3
endmodule

bind hdlc_rx_frame hdlc_rx_frame_chk #(.CHAR_MAX(CHAR_MAX), .BCAST_ADDR(BCAST_ADDR)) u_chk (
  .clk(clk), .rst_n(rst_n), .bit_en(bit_en), .cfg_char_bits(cfg_char_bits),
  .cfg_addr_en(cfg_addr_en), .cfg_station(cfg_station), .sync_pulse(sync_pulse),
  .char_valid(char_valid), .char_data(char_data), .char_first(char_first),
  .eof_valid(eof_valid), .abort_start(abort_start), .abort_end(abort_end)
);

// File: tb/hdlc_rx_frame_bench.sv
module hdlc_rx_frame_bench;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       bit_en = 1'b0, rx_bit = 1'b1;
  logic [2:0] cfg_char_bits = 3'd0;
  logic       cfg_addr_en = 1'b0;
  logic [7:0] cfg_station = 8'h00;
  logic       sync_pulse, char_valid, char_first, eof_valid, eof_crc_err;
  logic       abort_start, abort_end;
  logic [7:0] char_data;

  always #4 clk = ~clk;

  hdlc_rx_frame u_hdlc_rx_frame (
    .clk(clk), .rst_n(rst_n), .bit_en(bit_en), .rx_bit(rx_bit),
    .cfg_char_bits(cfg_char_bits), .cfg_addr_en(cfg_addr_en), .cfg_station(cfg_station),
    .sync_pulse(sync_pulse), .char_valid(char_valid), .char_data(char_data),
    .char_first(char_first), .eof_valid(eof_valid), .eof_crc_err(eof_crc_err),
    .abort_start(abort_start), .abort_end(abort_end)
  );

  int checks = 0, fails = 0;
  bit done = 0;

  // reference model state
  int          m_ones = 0;
  bit          m_active = 0, m_reject = 0, m_got = 0, m_first = 1;
  bit          m_q[$];
  bit          m_chr[$];
  logic [15:0] m_crc = 16'hFFFF;
  bit          e_sync, e_char, e_first, e_eof, e_crcerr, e_abs, e_abe;
  logic [7:0]  e_data;

  // observed counters
  int n_eof_ok = 0, n_eof_bad = 0, n_char = 0, n_abs = 0, n_abe = 0, n_sync = 0;

  // stimulus
  bit          raw[$];
  int          tx_run;
  logic [15:0] tx_crc;

  function automatic logic [15:0] crc_step(input logic [15:0] c, input bit b);
    logic [15:0] n;
    n = c >> 1;
    if (c[0] ^ b) n = n ^ 16'h8408;
    return n;
  endfunction

  task automatic check(input string req, input string what, input logic [15:0] act,
                       input logic [15:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  task automatic m_release(input bit r);
    int need;
    logic [7:0] v;
    m_got = 1;
    m_crc = crc_step(m_crc, r);
    if (m_reject) return;
    m_chr.push_back(r);
    need = (m_first || cfg_char_bits == 0) ? 8 : int'(cfg_char_bits);
    if (m_chr.size() == need) begin
      v = 0;
      foreach (m_chr[i]) v[i] = m_chr[i];
      m_chr.delete();
      if (m_first && cfg_addr_en && v != cfg_station && v != 8'hFF) m_reject = 1;
      else begin
        e_char = 1; e_data = v; e_first = m_first;
      end
      m_first = 0;
    end
  endtask

  task automatic m_data(input bit b);
    if (!m_active) return;
    m_q.push_back(b);
    if (m_q.size() > 7) m_release(m_q.pop_front());
  endtask

  task automatic model_bit(input bit b);
    if (b) begin
      if (m_ones == 6) begin e_abs = 1; m_active = 0; m_ones = 7; end
      else if (m_ones < 7) begin m_ones++; m_data(1); end
    end else begin
      if (m_ones == 6) begin
        e_sync = 1;
        if (m_active && !m_reject && m_got) begin e_eof = 1; e_crcerr = (m_crc != 16'hF0B8); end
        m_active = 1; m_reject = 0; m_got = 0; m_first = 1;
        m_q.delete(); m_chr.delete(); m_crc = 16'hFFFF;
      end else if (m_ones == 7) e_abe = 1;
      else if (m_ones != 5) m_data(0);
      m_ones = 0;
    end
  endtask

  task automatic compare_outputs();
    check("R1", "sync_pulse", sync_pulse, e_sync);
    check("R3", "char_valid", char_valid, e_char);
    if (e_char) begin
      check("R3", "char_data", char_data, e_data);
      check("R3", "char_first", char_first, e_first);
    end
    check("R5", "eof_valid", eof_valid, e_eof);
    if (e_eof) check("R4", "eof_crc_err", eof_crc_err, e_crcerr);
    check("R7", "abort_start", abort_start, e_abs);
    check("R8", "abort_end", abort_end, e_abe);
    if (sync_pulse) n_sync++;
    if (char_valid) n_char++;
    if (eof_valid && !eof_crc_err) n_eof_ok++;
    if (eof_valid && eof_crc_err) n_eof_bad++;
    if (abort_start) n_abs++;
    if (abort_end) n_abe++;
  endtask

  task automatic step(input bit en, input bit b);
    @(negedge clk);
    compare_outputs();
    {e_sync, e_char, e_first, e_eof, e_crcerr, e_abs, e_abe} = '0;
    bit_en = en; rx_bit = b;
    if (en) model_bit(b);
  endtask

  task automatic add_flag();
    raw.push_back(0);
    repeat (6) raw.push_back(1);
    raw.push_back(0);
    tx_run = 0;
  endtask

  task automatic add_bits(input logic [7:0] v, input bit upd);
    for (int i = 0; i < 8; i++) begin
      raw.push_back(v[i]);
      if (upd) tx_crc = crc_step(tx_crc, v[i]);
      if (v[i]) begin
        tx_run++;
        if (tx_run == 5) begin raw.push_back(0); tx_run = 0; end
      end else tx_run = 0;
    end
  endtask

  task automatic add_frame(input logic [7:0] bytes[$], input bit corrupt);
    logic [15:0] fcs;
    add_flag();
    tx_crc = 16'hFFFF;
    foreach (bytes[i]) add_bits(bytes[i], 1);
    fcs = ~tx_crc;
    if (corrupt) fcs[3] = ~fcs[3];
    add_bits(fcs[7:0], 0);
    add_bits(fcs[15:8], 0);
  endtask

  task automatic play(input bit gaps);
    int k = 0;
    while (raw.size() > 0) begin
      step(1, raw.pop_front());
      k++;
      if (gaps && (k % 3 == 0)) step(0, k[2]);
    end
    repeat (3) step(0, 1);
  endtask

  int s_ok, s_bad, s_ch, s_as, s_ae;
  task automatic snap();
    s_ok = n_eof_ok; s_bad = n_eof_bad; s_ch = n_char; s_as = n_abs; s_ae = n_abe;
  endtask

  initial begin
    #(200000 * 8);
    if (!done) begin
      fails++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    // R10: strobes low in reset
    check("R10", "reset strobes",
          {sync_pulse, char_valid, eof_valid, abort_start, abort_end}, 0);
    rst_n = 1'b1;

    // R10: data bits before any flag give nothing
    snap();
    for (int i = 0; i < 24; i++) step(1, i[0] ^ i[2]);
    check("R10", "chars before flag", n_char - s_ch, 0);

    // R2 R4 R5: good frame with stuffing-heavy bytes, idle flags first
    snap();
    add_flag(); add_flag();
    add_frame('{8'h12, 8'h7E, 8'hFF, 8'h3F, 8'hA5}, 0); add_flag();
    play(0);
    check("R2", "chars after destuffing", n_char - s_ch, 7);
    check("R4", "good eof", n_eof_ok - s_ok, 1);
    check("R4", "bad eof", n_eof_bad - s_bad, 0);

    // R4: corrupted FCS
    snap();
    add_frame('{8'h01, 8'hFE, 8'h80}, 1); add_flag();
    play(0);
    check("R4", "crc error eof", n_eof_bad - s_bad, 1);

    // R5: shared flag closes and opens; bare flags give no eof
    snap();
    add_frame('{8'hC3, 8'h3C}, 0); add_frame('{8'h55}, 0); add_flag();
    add_flag(); add_flag();
    play(0);
    check("R5", "shared flag eofs", n_eof_ok - s_ok, 2);

    // R3 R9: 5-bit characters with gaps in bit_en
    cfg_char_bits = 3'd5;
    snap();
    add_frame('{8'h9A, 8'h01, 8'hF7, 8'h7E, 8'h22, 8'hFF}, 0); add_flag();
    play(1);
    check("R3", "5-bit char count", n_char - s_ch, 12);
    check("R9", "gapped eof", n_eof_ok - s_ok, 1);
    cfg_char_bits = 3'd0;

    // R9: idle clocks with toggling data change nothing
    snap();
    for (int i = 0; i < 40; i++) step(0, i[0]);
    check("R9", "no events without bit_en", n_char - s_ch + n_abs - s_as, 0);

    // R6: address filter
    cfg_addr_en = 1'b1; cfg_station = 8'h5A;
    snap();
    add_frame('{8'h5A, 8'h10}, 0); add_flag(); play(0);
    check("R6", "station match eof", n_eof_ok - s_ok, 1);
    snap();
    add_frame('{8'hFF, 8'h10}, 0); add_flag(); play(0);
    check("R6", "broadcast eof", n_eof_ok - s_ok, 1);
    snap();
    add_frame('{8'h33, 8'h10, 8'h20}, 0); add_flag(); play(0);
    check("R6", "foreign eof", n_eof_ok - s_ok, 0);
    check("R6", "foreign chars", n_char - s_ch, 0);
    cfg_addr_en = 1'b0;

    // R7 R8: abort mid-frame then recovery
    snap();
    add_flag(); add_bits(8'h12, 0); add_bits(8'h34, 0);
    repeat (8) raw.push_back(1);
    raw.push_back(0);
    play(0);
    check("R7", "abort start count", n_abs - s_as, 1);
    check("R8", "abort end count", n_abe - s_ae, 1);
    check("R7", "aborted eof", n_eof_ok - s_ok + n_eof_bad - s_bad, 0);
    snap();
    add_flag(); add_frame('{8'h44, 8'h66}, 0); add_flag(); play(0);
    check("R7", "recovery eof", n_eof_ok - s_ok, 1);

    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule